// File: doc/BRIEF.md
# VFD Grid Multiplexer with Dimming

This block scans a vacuum fluorescent display one digit at a time. Each digit has its own grid slot. The block reads that digit's segment pattern from a display RAM and drives the grid and segment outputs from it. The digit count is selectable from 4 to 8, so the duty runs from 1/4 to 1/8. As digits are added, segment pins are taken away: the four pins on the boundary serve as grids 5 to 8 or as segments 12 down to 9, depending on the mode. Every grid slot is cut into 16 sub-steps. Brightness is set by how many of those sub-steps light the outputs, taken from a fixed non-linear table.

The block advances only on a one-clock `tick` strobe, which comes from the display oscillator. It presents the current digit number on `ram_addr`, and the RAM returns that digit's pattern on `ram_data` in the same cycle. Bits 7:0 of `ram_data` are the even byte, which drives segments 1 to 8. Bits 11:8 are the low nibble of the odd byte, which drives segments 9 to 12. `frame_end` pulses once per full scan.

Top module: `vfd_grid_mux`

## Requirements
- R1: While `rst_n` is low, `grid`, `shared`, `seg` and `frame_end` are 0 and `ram_addr` is 0. The scan restarts at digit 0, sub-step 0.
- R2: The digit count is 4 plus `mode` for `mode` values 0 to 4. Values 5 to 7 act as 8 digits. During slot d (0-based), only grid d is driven: `grid[d]` for d < 4, or `shared[d-4]` for d of 4 or more.
- R3: In the lit part of a slot, `seg[i]` equals `ram_data[i]` for i = 0..7.
- R4: Pin `shared[k]` (k = 0..3) acts as grid 5+k when the digit count is at least 5+k. Otherwise it acts as segment 12-k and carries `ram_data[11-k]` in the lit part of a slot.
- R5: A slot is lit during sub-steps 0 to N-1 and dark for the rest. N is set by `dim`: codes 0 to 7 give N = 1, 2, 4, 10, 11, 12, 13, 14. When dark, all of `grid`, `shared` and `seg` are 0.
- R6: When `disp_on` is 0, all of `grid`, `shared` and `seg` are 0.
- R7: A slot lasts 16 ticks. After the last digit's slot the scan wraps to digit 0. `frame_end` is high for exactly the one clock that follows the tick ending that last slot.
- R8: `ram_addr` equals the current digit. The outputs are registered and show the state reached at the previous clock edge.
- R9: Without a tick, the scan position does not move and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock sub-step strobe |
| mode | input | 3 | Digit-count code |
| dim | input | 3 | Dimming code |
| disp_on | input | 1 | Display enable |
| ram_addr | output | 3 | Digit whose pattern is requested |
| ram_data | input | 12 | Pattern for the digit on `ram_addr` (even byte, then odd low nibble) |
| grid | output | 4 | Grids 1 to 4, active high |
| shared | output | 4 | Grid 5+k or segment 12-k, by mode |
| seg | output | 8 | Segments 1 to 8, active high |
| frame_end | output | 1 | One-clock pulse after the last slot |

## Verification
The hardest case to reach from the ports is the full sweep of every shared pin through both of its roles, combined with every dimming width and the exact sub-step where the slot goes dark. Each part of that sweep only appears after a long run of ticks. The bench resets the block and then runs complete frames with mode and dim codes stepped together, from 0 up to 7. This covers every digit count, the aliased codes and every width. It also brings up the frame-wrap tick once per frame. Before every tick, the bench compares all outputs with a model that follows only the requirements.

// File: rtl/vfd_grid_mux.sv
module vfd_grid_mux #(
  parameter int MIN_DIGITS = 4,
  parameter int MAX_DIGITS = 8,
  parameter int SEG_BITS   = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       tick,
  input  logic [2:0]                                 mode,
  input  logic [2:0]                                 dim,
  input  logic                                       disp_on,
  output logic [$clog2(MAX_DIGITS)-1:0]              ram_addr,
  input  logic [SEG_BITS+MAX_DIGITS-MIN_DIGITS-1:0]  ram_data,
  output logic [MIN_DIGITS-1:0]                      grid,
  output logic [MAX_DIGITS-MIN_DIGITS-1:0]           shared,
  output logic [SEG_BITS-1:0]                        seg,
  output logic                                       frame_end
);
  localparam int SHR   = MAX_DIGITS - MIN_DIGITS;
  localparam int DIG_W = $clog2(MAX_DIGITS);
  localparam int CNT_W = DIG_W + 1;
  localparam int SUB_W = 4;

  logic [DIG_W-1:0] dig;
  logic [SUB_W-1:0] sub;
  logic [CNT_W-1:0] digits;
  logic [SUB_W:0]   width;
  logic             lit;
  logic [MAX_DIGITS-1:0] gvec;
  logic [SHR-1:0]   shr_n;

  assign digits = (mode > 3'(SHR)) ? CNT_W'(MAX_DIGITS) : CNT_W'(MIN_DIGITS) + CNT_W'(mode);

  always_comb begin
    case (dim)
      3'd0: width = 5'd1;
      3'd1: width = 5'd2;
      3'd2: width = 5'd4;
      3'd3: width = 5'd10;
      3'd4: width = 5'd11;
      3'd5: width = 5'd12;
      3'd6: width = 5'd13;
      default: width = 5'd14;
    endcase
  end

  wire slot_end = tick && (sub == {SUB_W{1'b1}});
  wire last_dig = {1'b0, dig} >= digits - CNT_W'(1);

  assign lit      = disp_on && ({1'b0, sub} < width);
  assign gvec     = lit ? (MAX_DIGITS'(1) << dig) : '0;
  assign ram_addr = dig;

  for (genvar k = 0; k < SHR; k++) begin : g_shr
    assign shr_n[k] = (digits >= CNT_W'(MIN_DIGITS + 1 + k))
                      ? gvec[MIN_DIGITS + k]
                      : (lit & ram_data[SEG_BITS + SHR - 1 - k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig       <= '0;
      sub       <= '0;
      frame_end <= 1'b0;
      grid      <= '0;
      shared    <= '0;
      seg       <= '0;
    end else begin
      frame_end <= slot_end && last_dig;
      if (tick) begin
        sub <= sub + SUB_W'(1);
        if (slot_end) dig <= last_dig ? '0 : dig + DIG_W'(1);
      end
      grid   <= gvec[MIN_DIGITS-1:0];
      shared <= shr_n;
      seg    <= lit ? ram_data[SEG_BITS-1:0] : '0;
    end
  end
endmodule

// File: rtl/vfd_grid_mux_chk.sv
module vfd_grid_mux_chk #(
  parameter int MIN_DIGITS = 4,
  parameter int MAX_DIGITS = 8,
  parameter int SEG_BITS   = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tick,
  input logic                            disp_on,
  input logic [3:0]                      sub,
  input logic [MIN_DIGITS-1:0]           grid,
  input logic [MAX_DIGITS-MIN_DIGITS-1:0] shared,
  input logic [SEG_BITS-1:0]             seg,
  input logic                            frame_end
);
  assert_grid_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid));

  assert_dark_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub >= 4'd14) |=> (grid == '0 && shared == '0 && seg == '0));

  assert_off_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> (grid == '0 && shared == '0 && seg == '0));

  assert_frame_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sub));
endmodule

bind vfd_grid_mux vfd_grid_mux_chk #(
  .MIN_DIGITS(MIN_DIGITS), .MAX_DIGITS(MAX_DIGITS), .SEG_BITS(SEG_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .disp_on(disp_on), .sub(sub),
  .grid(grid), .shared(shared), .seg(seg), .frame_end(frame_end)
);

// File: tb/test_vfd_grid_mux.sv
`timescale 1ns/1ps
module test_vfd_grid_mux;
  logic        clk = 0, rst_n = 0, tick = 0, disp_on = 0;
  logic [2:0]  mode = 0, dim = 0;
  logic [2:0]  ram_addr;
  logic [11:0] ram_data;
  logic [3:0]  grid, shared;
  logic [7:0]  seg;
  logic        frame_end;
  logic [11:0] mem [8];
  int checks = 0, failures = 0;
  int my_dig = 0, my_sub = 0;

  always #2 clk = ~clk;

  vfd_grid_mux i_vfd_grid_mux (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .dim(dim),
    .disp_on(disp_on), .ram_addr(ram_addr), .ram_data(ram_data),
    .grid(grid), .shared(shared), .seg(seg), .frame_end(frame_end));

  assign ram_data = mem[ram_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ndig(input logic [2:0] m);
    return (m > 3'd4) ? 8 : 4 + int'(m);
  endfunction

  function automatic int nwid(input logic [2:0] d);
    int t[8] = '{1, 2, 4, 10, 11, 12, 13, 14};
    return t[d];
  endfunction

  function automatic logic [15:0] model();
    logic [7:0] g;
    logic [3:0] s;
    logic       lit;
    lit = disp_on && (my_sub < nwid(dim));
    g = lit ? (8'd1 << my_dig) : 8'd0;
    for (int k = 0; k < 4; k++)
      s[k] = (ndig(mode) >= 5 + k) ? g[4+k] : (lit & mem[my_dig][11-k]);
    return {g[3:0], s, lit ? mem[my_dig][7:0] : 8'd0};
  endfunction

  task automatic check_outs(input string req);
    chk(req, {grid, shared, seg}, model());
    chk("R8", 32'(ram_addr), 32'(my_dig));
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; my_dig = 0; my_sub = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_tick();
    logic fe_exp;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    fe_exp = (my_sub == 15) && (my_dig == ndig(mode) - 1);
    chk("R7", 32'(frame_end), 32'(fe_exp));
    if (my_sub == 15) my_dig = (my_dig >= ndig(mode) - 1) ? 0 : my_dig + 1;
    my_sub = (my_sub + 1) % 16;
    @(negedge clk);
    chk("R7", 32'(frame_end), 32'd0);
  endtask

  task automatic test_reset_R1();
    @(negedge clk) rst_n = 0; disp_on = 1; mode = 3'd4; dim = 3'd7;
    repeat (3) @(negedge clk);
    chk("R1", {grid, shared, seg, frame_end}, 17'd0);
    chk("R1", 32'(ram_addr), 32'd0);
  endtask

  task automatic run_frame(input logic [2:0] m, input logic [2:0] d, input logic on, input string req);
    mode = m; dim = d; disp_on = on;
    do_reset();
    for (int i = 0; i < 16 * ndig(m) + 16; i++) begin
      check_outs(req);
      do_tick();
    end
    check_outs(req);
  endtask

  task automatic test_hold_R9();
    logic [15:0] snap;
    mode = 3'd2; dim = 3'd3; disp_on = 1;
    do_reset();
    repeat (21) do_tick();
    snap = {grid, shared, seg};
    repeat (30) @(negedge clk);
    chk("R9", {grid, shared, seg}, snap);
    check_outs("R9");
    do_tick();
    check_outs("R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 12'((i * 1657 + 613) ^ (i << 9));
    mem[0] = 12'hFFF;
    test_reset_R1();
    for (int i = 0; i < 8; i++) run_frame(3'(i), 3'(i), 1'b1, "R2 R3 R4 R5");
    run_frame(3'd0, 3'd7, 1'b1, "R4 R3");
    run_frame(3'd4, 3'd7, 1'b0, "R6");
    test_hold_R9();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule